// File: doc/BRIEF.md
# SRTS Residual Timestamp Generator

This block produces the 4-bit residual timestamps that an AAL1 transmit segmentation path inserts into its cell stream. A free-running 4-bit counter runs on the asynchronous network reference clock. Its Gray-coded value is carried into the timing domain through a two-stage synchroniser. A fractional accumulator, clocked by tick strobes from the selected timing bus clock, marks each group of eight cells. Its period is P×1024/Q timing ticks, where P is the number of scheduler frames and Q is the number of open channels.

On every eight-cell pulse the synchronised count is written into an eight-entry value FIFO. The transmit SAR drains that FIFO one value per read strobe. Two sticky flags record the FIFO's error cases: an overflow flag for a value dropped because the FIFO was full, and an underflow flag for a read from an empty FIFO. Each flag can be masked onto a single interrupt output.

The timing-bus inputs are single-cycle tick strobes that are already synchronous to `clk`.

Top module: `srts_stamp_gen`

## Requirements
- R1: While `cfg_enable` is 0, no eight-cell pulse fires, the accumulator returns to zero and the FIFO is emptied, so `stamp_avail` is 0 from the next cycle. A read while disabled returns 0 and sets the underflow flag.
- R2: `cfg_src_sel` picks the timing tick as follows. 2'b10 selects bus A, 2'b11 selects bus B, and 2'b00 or 2'b01 selects B when `tbus_b_active` is 1 and A otherwise. Ticks on the other bus have no effect.
- R3: The network count increments on every rising edge of `net_clk` and wraps modulo 16, independent of `cfg_enable`. The value stored at a write edge equals the count that was present at the `clk` rising edge two edges earlier.
- R4: On each enabled selected tick the accumulator adds Q. When the sum reaches P×1024, P×1024 is subtracted and `cell8_pulse` is high for the one cycle that follows that edge. A value is written into the FIFO at the same edge.
- R5: While P or Q is 0, no pulse fires and the accumulator holds.
- R6: The FIFO holds up to 8 values and returns them oldest first. A `sar_rd` strobe places the oldest value on `sar_stamp` from the next cycle. Without a read, `sar_stamp` holds. `stamp_avail` is 1 while enabled and non-empty.
- R7: A write to a full FIFO is dropped and sets `flag_ovf`. A read in the same cycle frees the room, so that write is accepted.
- R8: A read from an empty FIFO returns 0 on `sar_stamp` and sets `flag_unf`.
- R9: Both flags are sticky. Writing 1 to `flag_clr` bit 0 clears overflow, and writing 1 to bit 1 clears underflow. A new event in the same cycle wins over the clear.
- R10: `irq` is high when `flag_ovf` and `cfg_irq_en` bit 0 are both 1, or when `flag_unf` and `cfg_irq_en` bit 1 are both 1.
- R11: After reset, all outputs are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| net_clk | input | 1 | Network reference clock, asynchronous to clk |
| cfg_enable | input | 1 | Enables timestamp generation |
| cfg_src_sel | input | 2 | Timing source select |
| tbus_a_tick | input | 1 | Tick strobe from timing bus A |
| tbus_b_tick | input | 1 | Tick strobe from timing bus B |
| tbus_b_active | input | 1 | Bus B is the active timing bus |
| cfg_frames_p | input | 16 | P, frames in the scheduler |
| cfg_chans_q | input | 16 | Q, open channels |
| sar_rd | input | 1 | SAR read strobe |
| sar_stamp | output | 4 | Value returned by the last read |
| stamp_avail | output | 1 | FIFO holds at least one value |
| cell8_pulse | output | 1 | Eight-cell sampling pulse |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_unf | output | 1 | Sticky underflow flag |
| cfg_irq_en | input | 2 | Interrupt masks: bit 0 overflow, bit 1 underflow |
| flag_clr | input | 2 | Write-one-to-clear strobes for the flags |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted accumulator shows up first in the timing of `cell8_pulse`. The pulse either moves or disappears within one period of P×1024/Q ticks, and the FIFO occupancy and `stamp_avail` then drift in the same cycle. A wrong synchroniser stage count or a Gray decode error shows up as a wrong `sar_stamp` value on the first read after a pulse. A lost pointer or count shows up as a wrong value or a wrong flag within eight reads. The reference model tracks the network count, the accumulator and a queue every clock and compares every output each cycle, so any of these faults is reported within a few cycles of reaching a port.

// File: rtl/srts_pkg.sv
package srts_pkg;

    typedef enum logic [1:0] {
        TSRC_AUTO_0 = 2'b00,
        TSRC_AUTO_1 = 2'b01,
        TSRC_BUS_A  = 2'b10,
        TSRC_BUS_B  = 2'b11
    } tsrc_e;

    localparam int FLG_OVF = 0;
    localparam int FLG_UNF = 1;
    localparam int NUM_FLG = 2;

endpackage

// File: rtl/srts_net_counter.sv
module srts_net_counter #(
    parameter int CNT_W = 4
) (
    input  logic             net_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);

    typedef struct packed {
        logic [CNT_W-1:0] bin;
        logic [CNT_W-1:0] gray;
    } net_st_t;

    net_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + CNT_W'(1);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge net_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;

endmodule

// File: rtl/srts_gray_sync.sv
module srts_gray_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = gray_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bin_o[W-1] = st_q.pipe[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ st_q.pipe[STAGES-1][i];
        end
    end

endmodule

// File: rtl/srts_frac_pulse.sv
module srts_frac_pulse #(
    parameter int P_W = 16,
    parameter int Q_W = 16,
    parameter int SH  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  logic [P_W-1:0] p,
    input  logic [Q_W-1:0] q,
    output logic           fire_o,
    output logic           pulse_o
);

    localparam int ACC_W = ((P_W + SH) > Q_W ? (P_W + SH) : Q_W) + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] thr;
    logic [ACC_W-1:0] sum;
    logic             fire;

    assign thr = ACC_W'(p) << SH;
    assign sum = st_q.acc + ACC_W'(q);

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!en) begin
            st_d.acc = '0;
        end else if (tick && (p != '0) && (q != '0)) begin
            if (sum >= thr) begin
                st_d.acc = sum - thr;
                fire     = 1'b1;
            end else begin
                st_d.acc = sum;
            end
        end
        st_d.pulse = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o  = fire;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/srts_stamp_fifo.sv
module srts_stamp_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic [W-1:0] rd_data,
    output logic         avail,
    output logic         ovf_evt,
    output logic         unf_evt
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        head;
        logic [PTR_W-1:0]        tail;
        logic [LVL_W-1:0]        cnt;
        logic [W-1:0]            rdata;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     rd_ok, wr_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        rd_ok = rd && en && (st_q.cnt != '0);
        wr_ok = wr && en && ((st_q.cnt != LVL_W'(DEPTH)) || rd_ok);
        if (rd) begin
            st_d.rdata = rd_ok ? st_q.mem[st_q.head] : '0;
        end
        if (rd_ok) begin
            st_d.head = ptr_inc(st_q.head);
        end
        if (wr_ok) begin
            st_d.mem[st_q.tail] = wr_data;
            st_d.tail           = ptr_inc(st_q.tail);
        end
        st_d.cnt = st_q.cnt + LVL_W'(wr_ok) - LVL_W'(rd_ok);
        if (!en) begin
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign avail   = en && (st_q.cnt != '0);
    assign ovf_evt = wr && !wr_ok;
    assign unf_evt = rd && !rd_ok;

endmodule

// File: rtl/srts_stamp_gen.sv
module srts_stamp_gen #(
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 8,
    parameter int P_W    = 16,
    parameter int Q_W    = 16,
    parameter int SH     = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             net_clk,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_src_sel,
    input  logic             tbus_a_tick,
    input  logic             tbus_b_tick,
    input  logic             tbus_b_active,
    input  logic [P_W-1:0]   cfg_frames_p,
    input  logic [Q_W-1:0]   cfg_chans_q,
    input  logic             sar_rd,
    output logic [CNT_W-1:0] sar_stamp,
    output logic             stamp_avail,
    output logic             cell8_pulse,
    output logic             flag_ovf,
    output logic             flag_unf,
    input  logic [1:0]       cfg_irq_en,
    input  logic [1:0]       flag_clr,
    output logic             irq
);
    import srts_pkg::*;

    typedef struct packed {
        logic [NUM_FLG-1:0] flags;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [CNT_W-1:0]   net_gray;
    logic [CNT_W-1:0]   net_bin;
    logic               src_tick;
    logic               fire;
    logic               ovf_evt, unf_evt;
    logic [NUM_FLG-1:0] evt;

    srts_net_counter #(.CNT_W(CNT_W)) u_netcnt (
        .net_clk (net_clk),
        .rst_n   (rst_n),
        .gray_o  (net_gray)
    );

    srts_gray_sync #(.W(CNT_W), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_i (net_gray),
        .bin_o  (net_bin)
    );

    always_comb begin
        unique case (tsrc_e'(cfg_src_sel))
            TSRC_BUS_A: src_tick = tbus_a_tick;
            TSRC_BUS_B: src_tick = tbus_b_tick;
            default:    src_tick = tbus_b_active ? tbus_b_tick : tbus_a_tick;
        endcase
    end

    srts_frac_pulse #(.P_W(P_W), .Q_W(Q_W), .SH(SH)) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_enable),
        .tick    (src_tick),
        .p       (cfg_frames_p),
        .q       (cfg_chans_q),
        .fire_o  (fire),
        .pulse_o (cell8_pulse)
    );

    srts_stamp_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_enable),
        .wr      (fire),
        .wr_data (net_bin),
        .rd      (sar_rd),
        .rd_data (sar_stamp),
        .avail   (stamp_avail),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    always_comb begin
        evt          = '0;
        evt[FLG_OVF] = ovf_evt;
        evt[FLG_UNF] = unf_evt;
    end

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NUM_FLG; f++) begin
            st_d.flags[f] = (st_q.flags[f] && !flag_clr[f]) || evt[f];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_ovf = st_q.flags[FLG_OVF];
    assign flag_unf = st_q.flags[FLG_UNF];
    assign irq      = |(st_q.flags & cfg_irq_en);

endmodule

// File: rtl/srts_stamp_gen_chk.sv
module srts_stamp_gen_chk #(
    parameter int CNT_W = 4,
    parameter int Q_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [Q_W-1:0]   cfg_chans_q,
    input logic             sar_rd,
    input logic [CNT_W-1:0] sar_stamp,
    input logic             stamp_avail,
    input logic             cell8_pulse,
    input logic             flag_ovf,
    input logic             flag_unf,
    input logic [1:0]       flag_clr
);

    // R1
    dis_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !cell8_pulse);

    // R1
    dis_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !stamp_avail);

    // R5
    zero_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chans_q == '0) |=> !cell8_pulse);

    // R8
    empty_read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sar_rd && !stamp_avail) |=> flag_unf);

    // R8
    empty_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sar_rd && !stamp_avail) |=> (sar_stamp == '0));

    // R6
    hold_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sar_rd |=> $stable(sar_stamp));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovf && !flag_clr[0]) |=> flag_ovf);

    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unf && !flag_clr[1]) |=> flag_unf);

endmodule

bind srts_stamp_gen srts_stamp_gen_chk #(.CNT_W(CNT_W), .Q_W(Q_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_chans_q (cfg_chans_q),
    .sar_rd      (sar_rd),
    .sar_stamp   (sar_stamp),
    .stamp_avail (stamp_avail),
    .cell8_pulse (cell8_pulse),
    .flag_ovf    (flag_ovf),
    .flag_unf    (flag_unf),
    .flag_clr    (flag_clr)
);

// File: tb/srts_stamp_gen_tb_top.sv
`timescale 1ns/1ps
module srts_stamp_gen_tb_top;

    logic        clk = 1'b0;
    logic        net_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_src_sel = 2'b10;
    logic        tbus_a_tick = 1'b0;
    logic        tbus_b_tick = 1'b0;
    logic        tbus_b_active = 1'b0;
    logic [15:0] cfg_frames_p = 16'd1;
    logic [15:0] cfg_chans_q = 16'd0;
    logic        sar_rd = 1'b0;
    logic [3:0]  sar_stamp;
    logic        stamp_avail;
    logic        cell8_pulse;
    logic        flag_ovf;
    logic        flag_unf;
    logic [1:0]  cfg_irq_en = 2'b00;
    logic [1:0]  flag_clr = 2'b00;
    logic        irq;

    srts_stamp_gen dut_i (
        .clk(clk), .rst_n(rst_n), .net_clk(net_clk), .cfg_enable(cfg_enable),
        .cfg_src_sel(cfg_src_sel), .tbus_a_tick(tbus_a_tick), .tbus_b_tick(tbus_b_tick),
        .tbus_b_active(tbus_b_active), .cfg_frames_p(cfg_frames_p), .cfg_chans_q(cfg_chans_q),
        .sar_rd(sar_rd), .sar_stamp(sar_stamp), .stamp_avail(stamp_avail),
        .cell8_pulse(cell8_pulse), .flag_ovf(flag_ovf), .flag_unf(flag_unf),
        .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr), .irq(irq)
    );

    always #10 clk = ~clk;
    initial begin
        #7;
        forever #35 net_clk = ~net_clk;
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;
    string phase = "R11";

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Reference network count (R3)
    int netcnt = 0;
    always @(posedge net_clk or negedge rst_n) begin
        if (!rst_n) netcnt <= 0;
        else        netcnt <= netcnt + 1;
    end

    // Behavioural reference model
    int     fifo_q[$];
    longint m_acc = 0;
    bit     m_pulse = 0, m_ovf = 0, m_unf = 0;
    int     m_rd = 0;
    int     h1 = 0, h2 = 0;
    bit     m_tick, m_fire, e_ovf, e_unf;
    longint m_thr;

    always @(posedge clk) begin
        if (!rst_n) begin
            fifo_q.delete();
            m_acc = 0; m_pulse = 0; m_ovf = 0; m_unf = 0; m_rd = 0; h1 = 0; h2 = 0;
        end else begin
            m_tick = cfg_src_sel[1] ? (cfg_src_sel[0] ? tbus_b_tick : tbus_a_tick)
                                    : (tbus_b_active ? tbus_b_tick : tbus_a_tick);
            m_fire = 0; e_ovf = 0; e_unf = 0;
            m_thr  = longint'(cfg_frames_p) * 1024;
            if (!cfg_enable) m_acc = 0;
            else if (m_tick && cfg_frames_p != 0 && cfg_chans_q != 0) begin
                m_acc += longint'(cfg_chans_q);
                if (m_acc >= m_thr) begin
                    m_acc -= m_thr;
                    m_fire = 1;
                end
            end
            if (sar_rd) begin
                if (cfg_enable && fifo_q.size() > 0) m_rd = fifo_q.pop_front();
                else begin m_rd = 0; e_unf = 1; end
            end
            if (m_fire) begin
                if (fifo_q.size() < 8) fifo_q.push_back(h2);
                else e_ovf = 1;
            end
            if (!cfg_enable) fifo_q.delete();
            m_ovf   = (m_ovf && !flag_clr[0]) || e_ovf;
            m_unf   = (m_unf && !flag_clr[1]) || e_unf;
            m_pulse = m_fire;
            h2 = h1;
            h1 = netcnt % 16;
        end
    end

    int pulse_seen = 0;
    always @(posedge clk) begin
        #4;
        if (chk_on && rst_n) begin
            check("R4 cell8_pulse", int'(cell8_pulse), int'(m_pulse));
            check("R3/R6 sar_stamp", int'(sar_stamp), m_rd);
            check("R6 stamp_avail", int'(stamp_avail), int'(cfg_enable && fifo_q.size() > 0));
            check("R7 flag_ovf", int'(flag_ovf), int'(m_ovf));
            check("R8 flag_unf", int'(flag_unf), int'(m_unf));
            check("R10 irq", int'(irq), int'((m_ovf && cfg_irq_en[0]) || (m_unf && cfg_irq_en[1])));
            if (cell8_pulse) pulse_seen++;
        end
    end

    int a_pct = 0, b_pct = 0, rd_pct = 0;
    always @(negedge clk) begin
        tbus_a_tick <= ($urandom % 100) < a_pct;
        tbus_b_tick <= ($urandom % 100) < b_pct;
        sar_rd      <= ($urandom % 100) < rd_pct;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(17));
        cycles(5);
        rst_n = 1'b1;
        #6;
        // R11: reset state
        check("R11 sar_stamp", int'(sar_stamp), 0);
        check("R11 stamp_avail", int'(stamp_avail), 0);
        check("R11 cell8_pulse", int'(cell8_pulse), 0);
        check("R11 flags", int'({flag_ovf, flag_unf}), 0);
        check("R11 irq", int'(irq), 0);
        chk_on = 1'b1;
        cycles(2);

        // R2/R4: bus A, integer ratio
        phase = "R2 bus A";
        cfg_enable = 1; cfg_src_sel = 2'b10; cfg_frames_p = 1; cfg_chans_q = 64;
        a_pct = 100; b_pct = 50; rd_pct = 10;
        cycles(400);

        // R2: bus A selected, only bus B ticking -> no pulses
        phase = "R2 idle A";
        a_pct = 0; b_pct = 100; pulse_seen = 0;
        cycles(40);
        check("R2 no pulses from unselected bus", pulse_seen, 0);

        // R2/R4: bus B, fractional ratio
        phase = "R4 bus B";
        cfg_src_sel = 2'b11; cfg_frames_p = 3; cfg_chans_q = 1000;
        a_pct = 70; b_pct = 60; rd_pct = 30;
        cycles(400);

        // R2: follow-active modes
        phase = "R2 follow";
        cfg_src_sel = 2'b00; cfg_frames_p = 2; cfg_chans_q = 333;
        for (int i = 0; i < 8; i++) begin
            tbus_b_active = i[0];
            if (i == 4) cfg_src_sel = 2'b01;
            cycles(50);
        end

        // R7/R10: overflow
        phase = "R7 overflow";
        cfg_irq_en = 2'b01; rd_pct = 0; cfg_frames_p = 1; cfg_chans_q = 1024;
        a_pct = 100; b_pct = 100;
        cycles(100);
        check("R7 overflow set", int'(flag_ovf), 1);
        check("R10 irq on overflow", int'(irq), 1);

        // R5/R8: no pulses with Q=0, then P=0; reads drain and underflow
        phase = "R5 zero";
        cfg_chans_q = 0; rd_pct = 100; pulse_seen = 0; cfg_irq_en = 2'b10;
        cycles(40);
        cfg_chans_q = 500; cfg_frames_p = 0;
        cycles(40);
        check("R5 no pulses with zero operand", pulse_seen, 0);
        check("R8 underflow set", int'(flag_unf), 1);

        // R9: clear both flags
        phase = "R9 clear";
        rd_pct = 0;
        cycles(2);
        flag_clr = 2'b11;
        cycles(1);
        flag_clr = 2'b00;
        cycles(3);
        check("R9 flags cleared", int'({flag_ovf, flag_unf}), 0);
        check("R10 irq cleared", int'(irq), 0);

        // R1: fill, then disable
        phase = "R1 disable";
        cfg_frames_p = 1; cfg_chans_q = 1024;
        cycles(5);
        cfg_enable = 0; pulse_seen = 0;
        cycles(30);
        check("R1 empty while disabled", int'(stamp_avail), 0);
        check("R1 no pulses while disabled", pulse_seen, 0);
        rd_pct = 50;
        cycles(10);
        check("R1 read while disabled sets underflow", int'(flag_unf), 1);

        // Re-enable, mixed traffic
        phase = "R6 mixed";
        cfg_enable = 1; cfg_src_sel = 2'b10; cfg_frames_p = 5; cfg_chans_q = 2047;
        a_pct = 80; rd_pct = 25; cfg_irq_en = 2'b11;
        for (int i = 0; i < 6; i++) begin
            flag_clr = 2'b11;
            cycles(1);
            flag_clr = 2'b00;
            cycles(100);
        end
        chk_on = 1'b0;
        cycles(2);
        finish_run();
    end

endmodule